// File: doc/BRIEF.md
# Cascadable Thirty-Two Source Interrupt Controller

This block gathers 32 interrupt request lines into two request outputs, one for normal and one for critical service. Each line is first passed through a two-flop synchroniser. A per-source trigger-type bit and a per-source polarity bit then decide which input condition counts as a request. The four choices are rising edge, falling edge, active-high level and active-low level. A request latches a pending bit in a status word, and software clears that bit by writing a one to it.

A per-source enable word masks the status word. A per-source class bit sends each enabled pending source either to the normal output or to the critical output. Either output can drive a source input of a second instance, so several controllers can be chained.

Software reaches the registers through a single-cycle port. The port has a 4-bit word address, 32-bit write data and a write strobe. Read data is combinational from the address. The registers sit at word offsets 0x0 (status), 0x2 (enable), 0x3 (class), 0x4 (polarity), 0x5 (trigger type) and 0x6 (masked status). Every other offset is empty.

Top module: `irq_ctrl`

## Requirements
- R1: Input `src_i[n]` is source n. In every per-source register, source n is held at bit position 31-n.
- R2: Trigger-type bit 1 (offset 0x5) selects edge sensing and 0 selects level sensing. Polarity bit 1 (offset 0x4) selects rising edge or active-high level, and 0 selects falling edge or active-low level.
- R3: A change on a source input that is stable before a rising clock edge is not yet visible in status after the second rising edge. It is visible after the third.
- R4: Writing offset 0x0 clears each status bit written as 1. Bits written as 0 keep their value.
- R5: When a set and a clear reach the same status bit in the same cycle, the set wins. A level source that is still active therefore stays pending after a clear.
- R6: Offset 0x6 reads as status AND enable. Writes to offset 0x6 change no register.
- R7: `irq_o` is high when some enabled pending source has class bit 0 (offset 0x3). `crit_o` is high when some enabled pending source has class bit 1. Both outputs are low while enable is zero.
- R8: While reset is held, status, enable, class, polarity and trigger type all read as zero and both outputs are low.
- R9: Offsets 0x1 and 0x7 through 0xF read as zero, and writes to them change no register.
- R10: An edge source sets its status bit only on a new active edge. After a clear, an input held at its new level leaves the bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source lines, bit n is source n |
| addr_i | input | 4 | Register word offset |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Normal-class interrupt request |
| crit_o | output | 1 | Critical-class interrupt request |

## Verification
The hardest case to reach from the ports is a status set and a software clear landing on the same bit in the same clock cycle. Only an edge source produces a set that lasts exactly one cycle, and that cycle comes three edges after the input changes.

The bench reaches it by switching a rising-edge source at a falling clock edge. It counts two rising edges, then holds a clear-all write across the third rising edge. Status must still show the bit afterwards.

A second clear, made while the input is held high, must then take effect and stay in effect.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 4;
  localparam logic [AW-1:0] OFF_STAT = 4'h0;
  localparam logic [AW-1:0] OFF_EN   = 4'h2;
  localparam logic [AW-1:0] OFF_CRIT = 4'h3;
  localparam logic [AW-1:0] OFF_POL  = 4'h4;
  localparam logic [AW-1:0] OFF_TRIG = 4'h5;
  localparam logic [AW-1:0] OFF_MSK  = 4'h6;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur_o = s2_q;
  assign prv_o = s3_q;
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prv_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] trig_i,
  output logic [W-1:0] set_o
);
  for (genvar i = 0; i < W; i++) begin : g_src
    logic act, edg;
    assign act = pol_i[i] ? cur_i[i] : ~cur_i[i];
    assign edg = pol_i[i] ? (cur_i[i] & ~prv_i[i]) : (~cur_i[i] & prv_i[i]);
    assign set_o[i] = trig_i[i] ? edg : act;
  end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & $past(clr_i & ~set_i)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i))); // R5
  AST_NO_SPONTANEOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(set_i)) == '0)); // R10
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned W = NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          we_i,
  input  logic [W-1:0]  status_i,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  crit_o,
  output logic [W-1:0]  pol_o,
  output logic [W-1:0]  trig_o,
  output logic [W-1:0]  clr_o,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] en_q, crit_q, pol_q, trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (we_i) begin
      if (addr_i == OFF_EN)   en_q   <= wdata_i;
      if (addr_i == OFF_CRIT) crit_q <= wdata_i;
      if (addr_i == OFF_POL)  pol_q  <= wdata_i;
      if (addr_i == OFF_TRIG) trig_q <= wdata_i;
    end
  end

  assign clr_o = (we_i && addr_i == OFF_STAT) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      OFF_STAT: rdata_o = status_i;
      OFF_EN:   rdata_o = en_q;
      OFF_CRIT: rdata_o = crit_q;
      OFF_POL:  rdata_o = pol_q;
      OFF_TRIG: rdata_o = trig_q;
      OFF_MSK:  rdata_o = status_i & en_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign crit_o = crit_q;
  assign pol_o  = pol_q;
  assign trig_o = trig_q;

  logic cfg_addr;
  assign cfg_addr = (addr_i == OFF_EN) || (addr_i == OFF_CRIT) ||
                    (addr_i == OFF_POL) || (addr_i == OFF_TRIG);

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !cfg_addr) |=> $stable({en_q, crit_q, pol_q, trig_q})); // R9
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 4'h1 || addr_i > OFF_MSK) |-> (rdata_o == '0)); // R9
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic            we_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o,
  output logic            crit_o
);
  logic [NSRC-1:0] src_map, cur, prv, set, clr, status;
  logic [NSRC-1:0] en, crit, pol, trig, masked;

  // source n lands on register bit NSRC-1-n
  for (genvar n = 0; n < NSRC; n++) begin : g_map
    assign src_map[NSRC-1-n] = src_i[n];
  end

  irq_sync #(.W(NSRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_map), .cur_o(cur), .prv_o(prv)
  );

  irq_detect #(.W(NSRC)) u_det (
    .cur_i(cur), .prv_i(prv), .pol_i(pol), .trig_i(trig), .set_o(set)
  );

  irq_status #(.W(NSRC)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set), .clr_i(clr), .status_o(status)
  );

  irq_regs #(.W(NSRC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .status_i(status), .en_o(en), .crit_o(crit), .pol_o(pol),
    .trig_o(trig), .clr_o(clr), .rdata_o(rdata_o)
  );

  assign masked = status & en;
  assign irq_o  = |(masked & ~crit);
  assign crit_o = |(masked & crit);

  AST_QUIET_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> (!irq_o && !crit_o)); // R7
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src = '0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq, crit;
  int          errs = 0;
  int          checks = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .irq_o(irq), .crit_o(crit)
  );

  typedef struct packed {
    logic       trig;
    logic       pol;
    logic       start;
    logic       fin;
    logic       exp;
    logic [4:0] s;
  } row_t;

  localparam row_t ROWS [9] = '{
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd12},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd13},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd14},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd15},
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 5'd16},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd17},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'd18},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd19},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd20}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    // R8: reset values while reset is held
    #35;
    rd(4'h0, v); chk("R8 status", v, 32'h0);
    rd(4'h2, v); chk("R8 enable", v, 32'h0);
    rd(4'h3, v); chk("R8 class", v, 32'h0);
    rd(4'h4, v); chk("R8 polarity", v, 32'h0);
    rd(4'h5, v); chk("R8 trigger", v, 32'h0);
    chk("R8 outputs", {30'h0, irq, crit}, 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    // make all sources active-high level, then clear
    wr(4'h4, 32'hFFFF_FFFF);
    clks(4);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R4 clear all", v, 32'h0);

    // R1: source 0 maps to bit 31
    src[0] = 1'b1;
    clks(4);
    rd(4'h0, v); chk("R1 source0 bit31", v, 32'h8000_0000);
    src[0] = 1'b0;
    clks(4);
    wr(4'h0, 32'hFFFF_FFFF);

    // R3: synchroniser latency, source 5 -> bit 26
    @(negedge clk); src[5] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rd(4'h0, v); chk("R3 not yet after 2 edges", v & 32'h0400_0000, 32'h0);
    @(posedge clk); #1;
    rd(4'h0, v); chk("R3 set after 3 edges", v & 32'h0400_0000, 32'h0400_0000);

    // R5: active level source re-latches over a clear
    wr(4'h0, 32'h0400_0000);
    rd(4'h0, v); chk("R5 level stays pending", v & 32'h0400_0000, 32'h0400_0000);

    // R6 / R7: masking and class routing
    chk("R7 no output while disabled", {30'h0, irq, crit}, 32'h0);
    rd(4'h6, v); chk("R6 masked view disabled", v, 32'h0);
    wr(4'h2, 32'h0400_0000);
    rd(4'h6, v); chk("R6 masked view enabled", v, 32'h0400_0000);
    chk("R7 normal output", {30'h0, irq, crit}, 32'h2);
    wr(4'h3, 32'h0400_0000);
    chk("R7 critical output", {30'h0, irq, crit}, 32'h1);
    wr(4'h6, 32'h0);
    rd(4'h6, v); chk("R6 write ignored", v, 32'h0400_0000);
    rd(4'h2, v); chk("R6 enable untouched", v, 32'h0400_0000);

    // R9: empty offsets
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h7, 32'hFFFF_FFFF);
    wr(4'hF, 32'hFFFF_FFFF);
    rd(4'h1, v); chk("R9 read 0x1", v, 32'h0);
    rd(4'h7, v); chk("R9 read 0x7", v, 32'h0);
    rd(4'h8, v); chk("R9 read 0x8", v, 32'h0);
    rd(4'h2, v); chk("R9 enable untouched", v, 32'h0400_0000);
    rd(4'h3, v); chk("R9 class untouched", v, 32'h0400_0000);
    rd(4'h5, v); chk("R9 trigger untouched", v, 32'h0);
    wr(4'h2, 32'h0); wr(4'h3, 32'h0);
    src[5] = 1'b0;
    clks(4);
    wr(4'h0, 32'h0400_0000);
    rd(4'h0, v); chk("R4 level clear after release", v & 32'h0400_0000, 32'h0);

    // R2 table over trigger and polarity modes
    foreach (ROWS[k]) begin
      logic [31:0] b;
      b = 32'h8000_0000 >> ROWS[k].s;
      @(negedge clk); src = '0; src[ROWS[k].s] = ROWS[k].start;
      wr(4'h5, ROWS[k].trig ? b : 32'h0);
      wr(4'h4, ROWS[k].pol ? 32'hFFFF_FFFF : ~b);
      clks(4);
      wr(4'h0, 32'hFFFF_FFFF);
      @(negedge clk); src[ROWS[k].s] = ROWS[k].fin;
      clks(4);
      rd(4'h0, v);
      chk($sformatf("R2 row %0d", k), v & b, ROWS[k].exp ? b : 32'h0);
    end
    @(negedge clk); src = '0;
    wr(4'h4, 32'hFFFF_FFFF);
    clks(4);

    // R5: edge set and clear in the same cycle, source 9 -> bit 22
    wr(4'h5, 32'h0040_0000);
    wr(4'h0, 32'hFFFF_FFFF);
    @(negedge clk); src[9] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 4'h0; wdata = 32'hFFFF_FFFF; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(4'h0, v); chk("R5 set beats clear", v & 32'h0040_0000, 32'h0040_0000);

    // R4: zero write keeps bit
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R4 zero write keeps", v & 32'h0040_0000, 32'h0040_0000);

    // R10: clear with input held stays clear
    wr(4'h0, 32'h0040_0000);
    clks(5);
    rd(4'h0, v); chk("R10 edge held no reset", v & 32'h0040_0000, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule